// File: doc/BRIEF.md
# E1 Timeslot-16 Signaling Inserter

This block places per-channel signaling into timeslot 16 of an outgoing E1 bit stream. A host keeps sixteen 8-bit signaling registers up to date through a one-cycle write port. Each register carries the four signaling bits of two voice channels: the upper nibble belongs to channel n and the lower nibble to channel n+16. The first register instead carries the multiframe alignment word, a remote multiframe alarm and three spare bits.

The block takes a bit strobe, a frame-start strobe and a multiframe-start strobe from the transmit framer together with the serial data. When the multiframe-start strobe arrives, all sixteen registers are copied at once into a shadow bank, and a status flag goes up so the host knows it has one full multiframe (2 ms) to write fresh values. While the shadow bank is being sent, the host may rewrite the registers without disturbing the multiframe already on the wire. If the host writes nothing, the same values go out again. Frame n of the multiframe carries shadow byte n in timeslot 16, MSB first.

A mode input selects channel-associated signaling, where the alignment nibble is forced to zero, or common-channel signaling, where the sixteen bytes are sent as written. When insertion is disabled, timeslot 16 passes through untouched.

Top module: `cas_tx_inserter`

## Requirements
- R1: After reset, ser_out is 1 and mf_flag is 0. Register 0 holds 8'h0B (bits 7:4 alignment = 0000, bit 2 alarm = 0, spare bits 3, 1 and 0 = 1), and registers 1 to 15 hold 8'h00. The shadow bank starts with the same values.
- R2: With ins_en = 0, every bit of the frame, timeslot 16 included, comes out on ser_out one clock after the bit_stb cycle that presented it on ser_in. ser_out changes only after a bit_stb cycle.
- R3: With ins_en = 1, bits at frame positions outside 128 to 135 pass from ser_in to ser_out unchanged, with the same one-clock latency.
- R4: With ins_en = 1, frame f (0 to 15, counted from the multiframe-start strobe) carries shadow byte f in positions 128 to 135. Bit 7 goes out at position 128 and bit 0 at position 135. A frame's position 0 is the bit_stb cycle on which frm_stb is high.
- R5: The multiframe boundary is the bit_stb cycle on which frm_stb and mf_stb are both high. On that cycle every register is copied into the shadow bank. A write on the boundary cycle or later reaches the line only at the next boundary. Without new writes, each multiframe repeats the previous bytes.
- R6: With ccs_mode = 0 at the boundary, shadow byte 0 gets bits 7:4 forced to 0000 whatever was written, while bits 3:0 (alarm at bit 2, spares at bits 3, 1 and 0) are copied as written.
- R7: With ccs_mode = 1 at the boundary, all 8 bits of register 0 are copied into shadow byte 0 unchanged.
- R8: mf_flag is 1 from the clock after each boundary until flag_clr is seen on a non-boundary cycle. A boundary on the same cycle as flag_clr leaves the flag set. Between boundaries the flag does not set by itself.
- R9: A cycle with wr_en = 1 stores wr_data in the register at wr_addr (0 to 15). No other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One cycle per line bit |
| frm_stb | input | 1 | With bit_stb, marks frame bit position 0 |
| mf_stb | input | 1 | With frm_stb, marks frame 0 of the multiframe |
| ser_in | input | 1 | Serial data from the framer |
| ser_out | output | 1 | Serial data with timeslot 16 possibly replaced |
| ins_en | input | 1 | 1 = replace timeslot 16 with shadow bytes |
| ccs_mode | input | 1 | 0 = channel-associated (alignment forced), 1 = common-channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| flag_clr | input | 1 | Clears mf_flag |
| mf_flag | output | 1 | Multiframe boundary seen, time to refresh |

## Verification
The bench captures timeslot 16 of every frame and compares all sixteen bytes against the values written. A design that sends the bytes in the wrong frame order, bit-reversed or one bit late fails these byte compares. A write placed just after a boundary must not appear until the following multiframe. A design that reads the live registers instead of a snapshot sends the new value one multiframe early. Further tests send register 0 with a nonzero upper nibble in both modes, which catches forcing done at write time instead of at load time. Others clear the flag on the boundary cycle itself and let two boundaries pass without a clear, which catches a clear that wins over a set.

// File: rtl/cas_tx_pkg.sv
package cas_tx_pkg;

    // Width of one timeslot byte.
    localparam int unsigned SIG_W      = 8;
    // Defaults for the top-level geometry.
    localparam int unsigned SIG_REGS   = 16;
    localparam int unsigned FRAME_LEN  = 256;
    localparam int unsigned SIG_SLOT   = 16;
    // Register 0 after reset: alignment 0000, spare bits 3,1,0 high, alarm (bit 2) low.
    localparam logic [SIG_W-1:0] FIRST_RST = 8'b0000_1011;

    typedef enum logic {
        MODE_CAS = 1'b0,
        MODE_CCS = 1'b1
    } sig_mode_e;

    function automatic logic [SIG_W-1:0] reg_reset_value(input int unsigned idx);
        return (idx == 0) ? FIRST_RST : '0;
    endfunction

    // Value placed in the shadow bank when the boundary copy happens.
    function automatic logic [SIG_W-1:0] load_value(input logic [SIG_W-1:0] raw,
                                                    input sig_mode_e       mode,
                                                    input logic            first);
        if (first && mode == MODE_CAS)
            return {{(SIG_W/2){1'b0}}, raw[SIG_W/2-1:0]};
        return raw;
    endfunction

endpackage

// File: rtl/cas_timing.sv
module cas_timing
    import cas_tx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = FRAME_LEN,
    parameter int unsigned MF_FRAMES  = SIG_REGS,
    parameter int unsigned SLOT_IDX   = SIG_SLOT,
    localparam int unsigned PW = $clog2(FRAME_BITS),
    localparam int unsigned FW = $clog2(MF_FRAMES),
    localparam int unsigned BW = $clog2(SIG_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb,
    input  logic          frm_stb,
    input  logic          mf_stb,
    output logic          boundary,
    output logic          in_slot,
    output logic [FW-1:0] frame_idx,
    output logic [BW-1:0] bit_sel
);

    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] SLOT_LO  = PW'(SLOT_IDX * SIG_W);
    localparam logic [PW-1:0] SLOT_HI  = PW'(SLOT_IDX * SIG_W + SIG_W - 1);
    localparam logic [FW-1:0] LAST_FRM = FW'(MF_FRAMES - 1);

    logic [PW-1:0] bit_cnt;
    logic [PW-1:0] pos_now;
    logic [FW-1:0] frm_cnt;

    // Position of the bit presented on this bit_stb cycle.
    assign pos_now = frm_stb ? '0 : bit_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            bit_cnt <= '0;
        else if (bit_stb)
            bit_cnt <= (pos_now == LAST_POS) ? '0 : pos_now + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            frm_cnt <= '0;
        else if (bit_stb && frm_stb)
            frm_cnt <= mf_stb ? '0 : ((frm_cnt == LAST_FRM) ? '0 : frm_cnt + FW'(1));
    end

    assign boundary  = bit_stb && frm_stb && mf_stb;
    assign in_slot   = bit_stb && (pos_now >= SLOT_LO) && (pos_now <= SLOT_HI);
    assign frame_idx = frm_cnt;
    // Slot starts on a byte multiple, so the low bits count 0..7; MSB goes first.
    assign bit_sel   = ~pos_now[BW-1:0];

    AST_MF_FRAME0: assert property (@(posedge clk) disable iff (rst)
        boundary |=> frame_idx == '0);  // R4

endmodule

// File: rtl/cas_reg_bank.sv
module cas_reg_bank
    import cas_tx_pkg::*;
#(
    parameter int unsigned NREG = SIG_REGS,
    localparam int unsigned AW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [SIG_W-1:0]           wr_data,
    output logic [NREG-1:0][SIG_W-1:0] regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reg_reset_value(i);
            else if (wr_en && wr_addr == AW'(i))
                regs[i] <= wr_data;
        end

        AST_WR_ONLY_TARGET: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == AW'(i)) |=> $stable(regs[i]));  // R9
    end

endmodule

// File: rtl/cas_shadow.sv
module cas_shadow
    import cas_tx_pkg::*;
#(
    parameter int unsigned NREG = SIG_REGS,
    localparam int unsigned FW = $clog2(NREG),
    localparam int unsigned BW = $clog2(SIG_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       boundary,
    input  sig_mode_e                  mode,
    input  logic [NREG-1:0][SIG_W-1:0] regs,
    input  logic [FW-1:0]              frame_idx,
    input  logic [BW-1:0]              bit_sel,
    output logic                       sig_bit
);

    logic [NREG-1:0][SIG_W-1:0] shadow;

    for (genvar i = 0; i < NREG; i++) begin : g_shd
        always_ff @(posedge clk) begin
            if (rst)
                shadow[i] <= reg_reset_value(i);
            else if (boundary)
                shadow[i] <= load_value(regs[i], mode, i == 0);
        end
    end

    assign sig_bit = shadow[frame_idx][bit_sel];

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(shadow));  // R5
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        boundary && mode == MODE_CAS |=> shadow[0][SIG_W-1:SIG_W/2] == '0);  // R6
    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        boundary |=> shadow[0][SIG_W/2-1:0] == $past(regs[0][SIG_W/2-1:0]));  // R6
    AST_CCS_RAW: assert property (@(posedge clk) disable iff (rst)
        boundary && mode == MODE_CCS |=> shadow[0] == $past(regs[0]));  // R7

endmodule

// File: rtl/cas_mf_flag.sv
module cas_mf_flag (
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic flag_clr,
    output logic mf_flag
);

    always_ff @(posedge clk) begin
        if (rst)
            mf_flag <= 1'b0;
        else if (boundary)
            mf_flag <= 1'b1;
        else if (flag_clr)
            mf_flag <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        boundary |=> mf_flag);  // R8
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !boundary |=> !mf_flag);  // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary && !flag_clr |=> $stable(mf_flag));  // R8

endmodule

// File: rtl/cas_tx_inserter.sv
module cas_tx_inserter
    import cas_tx_pkg::*;
#(
    parameter int unsigned NREG       = SIG_REGS,
    parameter int unsigned FRAME_BITS = FRAME_LEN,
    parameter int unsigned SLOT_IDX   = SIG_SLOT,
    localparam int unsigned AW = $clog2(NREG),
    localparam int unsigned FW = $clog2(NREG),
    localparam int unsigned BW = $clog2(SIG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             frm_stb,
    input  logic             mf_stb,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             ins_en,
    input  logic             ccs_mode,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [SIG_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic             mf_flag
);

    logic                       boundary;
    logic                       in_slot;
    logic [FW-1:0]              frame_idx;
    logic [BW-1:0]              bit_sel;
    logic [NREG-1:0][SIG_W-1:0] regs;
    logic                       sig_bit;
    sig_mode_e                  mode;

    assign mode = sig_mode_e'(ccs_mode);

    cas_timing #(
        .FRAME_BITS (FRAME_BITS),
        .MF_FRAMES  (NREG),
        .SLOT_IDX   (SLOT_IDX)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .frm_stb   (frm_stb),
        .mf_stb    (mf_stb),
        .boundary  (boundary),
        .in_slot   (in_slot),
        .frame_idx (frame_idx),
        .bit_sel   (bit_sel)
    );

    cas_reg_bank #(.NREG(NREG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    cas_shadow #(.NREG(NREG)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .mode      (mode),
        .regs      (regs),
        .frame_idx (frame_idx),
        .bit_sel   (bit_sel),
        .sig_bit   (sig_bit)
    );

    cas_mf_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .flag_clr (flag_clr),
        .mf_flag  (mf_flag)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ser_out <= 1'b1;
        else if (bit_stb)
            ser_out <= (ins_en && in_slot) ? sig_bit : ser_in;
    end

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        bit_stb && !ins_en |=> ser_out == $past(ser_in));  // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(ser_out));  // R2
    AST_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (rst)
        bit_stb && ins_en && !in_slot |=> ser_out == $past(ser_in));  // R3

endmodule

// File: tb/tb_cas_tx_inserter.sv
module tb_cas_tx_inserter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0, frm_stb = 1'b0, mf_stb = 1'b0, ser_in = 1'b0;
    logic       ser_out;
    logic       ins_en = 1'b0, ccs_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       mf_flag;

    always #4 clk = ~clk;  // 125 MHz

    cas_tx_inserter dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .frm_stb(frm_stb), .mf_stb(mf_stb),
        .ser_in(ser_in), .ser_out(ser_out), .ins_en(ins_en), .ccs_mode(ccs_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_clr(flag_clr), .mf_flag(mf_flag)
    );

    // {addr, written byte, expected on the line in channel-associated mode}
    localparam logic [19:0] VEC [16] = '{
        {4'd0,  8'hF4, 8'h04}, {4'd1,  8'hA5, 8'hA5}, {4'd2,  8'h5A, 8'h5A}, {4'd3,  8'h3C, 8'h3C},
        {4'd4,  8'hC3, 8'hC3}, {4'd5,  8'h0F, 8'h0F}, {4'd6,  8'hF0, 8'hF0}, {4'd7,  8'h81, 8'h81},
        {4'd8,  8'h7E, 8'h7E}, {4'd9,  8'h96, 8'h96}, {4'd10, 8'h69, 8'h69}, {4'd11, 8'h12, 8'h12},
        {4'd12, 8'hED, 8'hED}, {4'd13, 8'hB4, 8'hB4}, {4'd14, 8'h4B, 8'h4B}, {4'd15, 8'hFF, 8'hFF}
    };

    int n_chk = 0, n_bad = 0;
    int bnd_cnt = 0, cap_cnt = 0, pass_err = 0;
    logic gen_on = 1'b0, clr_now = 1'b0, clr_at_bnd = 1'b0;
    logic [7:0] cap_cur [16];
    logic [7:0] sin_cur [16];
    logic [7:0] cap_mf  [16];
    logic [7:0] sin_mf  [16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Line timing generator and output monitor, one step per falling edge.
    initial begin
        int   gbit = 0, gframe = 0;
        logic phase = 1'b0;
        logic prev_bit = 1'b0, prev_sin = 1'b0;
        int   prev_pos = 0, prev_frm = 0;
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            if (prev_bit) begin
                if (prev_pos >= 128 && prev_pos <= 135) begin
                    cap_cur[prev_frm][135 - prev_pos] = ser_out;
                    sin_cur[prev_frm][135 - prev_pos] = prev_sin;
                    if (prev_pos == 135 && prev_frm == 15) begin
                        cap_mf = cap_cur;
                        sin_mf = sin_cur;
                        cap_cnt++;
                    end
                end else if (ser_out !== prev_sin) begin
                    pass_err++;
                end
            end
            flag_clr = 1'b0;
            if (clr_now) begin flag_clr = 1'b1; clr_now = 1'b0; end
            if (gen_on && phase) begin
                bit_stb = 1'b1;
                frm_stb = (gbit == 0);
                mf_stb  = (gbit == 0 && gframe == 0);
                lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ser_in  = lfsr[0];
                if (mf_stb) begin
                    bnd_cnt++;
                    if (clr_at_bnd) begin flag_clr = 1'b1; clr_at_bnd = 1'b0; end
                end
                prev_bit = 1'b1; prev_pos = gbit; prev_frm = gframe; prev_sin = ser_in;
                if (gbit == 255) begin
                    gbit = 0;
                    gframe = (gframe == 15) ? 0 : gframe + 1;
                end else begin
                    gbit = gbit + 1;
                end
            end else begin
                bit_stb = 1'b0; frm_stb = 1'b0; mf_stb = 1'b0; prev_bit = 1'b0;
            end
            if (gen_on) phase = ~phase;
        end
    end

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_bnd();
        int b = bnd_cnt;
        while (bnd_cnt == b) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_cap();
        int c = cap_cnt;
        while (cap_cnt == c) @(negedge clk);
    endtask

    task automatic run_mf();
        wait_bnd();
        wait_cap();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        chk("R1 ser_out after reset", ser_out, 1);
        chk("R1 mf_flag after reset", mf_flag, 0);
        rst = 1'b0;
        ins_en = 1'b1;
        gen_on = 1'b1;

        // First multiframe: reset register contents on the line.
        wait_cap();
        chk("R1 register 0 reset byte", cap_mf[0], 8'h0B);
        chk("R1 register 5 reset byte", cap_mf[5], 8'h00);
        chk("R1 register 15 reset byte", cap_mf[15], 8'h00);
        chk("R8 flag set after boundary", mf_flag, 1);

        // R8: clear between boundaries, then no self-set.
        clr_now = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 flag cleared", mf_flag, 0);
        repeat (100) @(negedge clk);
        chk("R8 flag stays clear between boundaries", mf_flag, 0);

        // Table walk: all sixteen registers, compared in the next multiframe.
        wait_bnd();
        for (int k = 0; k < 16; k++) host_write(VEC[k][19:16], VEC[k][15:8]);
        run_mf();
        for (int k = 0; k < 16; k++)
            chk("R4 R9 R6 slot byte per frame", cap_mf[VEC[k][19:16]], VEC[k][7:0]);

        // R5: no refresh, same bytes again.
        run_mf();
        chk("R5 resend register 7", cap_mf[7], 8'h81);
        chk("R5 resend register 0", cap_mf[0], 8'h04);

        // R5: write after the copy does not touch the multiframe in progress.
        wait_bnd();
        host_write(4'd3, 8'h99);
        wait_cap();
        chk("R5 mid-multiframe write not yet sent", cap_mf[3], 8'h3C);
        run_mf();
        chk("R5 write sent next multiframe", cap_mf[3], 8'h99);
        chk("R9 neighbour register unchanged", cap_mf[4], 8'hC3);

        // R7: common-channel mode sends register 0 raw.
        ccs_mode = 1'b1;
        run_mf();
        chk("R7 register 0 raw in common-channel mode", cap_mf[0], 8'hF4);
        ccs_mode = 1'b0;
        run_mf();
        chk("R6 alignment forced again", cap_mf[0], 8'h04);

        // R2: insertion disabled, slot passes through.
        ins_en = 1'b0;
        run_mf();
        chk("R2 frame 0 slot passes through", cap_mf[0], sin_mf[0]);
        chk("R2 frame 9 slot passes through", cap_mf[9], sin_mf[9]);
        ins_en = 1'b1;

        // R8: clear on the boundary cycle loses to the set.
        clr_now = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 flag cleared before boundary", mf_flag, 0);
        clr_at_bnd = 1'b1;
        wait_bnd();
        chk("R8 set wins over same-cycle clear", mf_flag, 1);
        run_mf();
        chk("R8 flag stays set across boundaries", mf_flag, 1);

        // R3: every bit outside the slot matched ser_in.
        chk("R3 R2 bits outside slot pass through", pass_err, 0);

        summary();
        $finish;
    end

endmodule